// File: doc/BRIEF.md
# Record-Dropping Input Queue

This block is a synchronous word queue placed between an untrusted input port and an internal drain engine. Words arrive with a valid strobe and an end-of-record marker. Every arriving word gets the same acknowledge, whatever the fill level or internal state. The sender therefore never sees back-pressure and cannot learn how full the queue is or whether a record was lost.

A word can arrive while the queue already holds `DEPTH` words. That word is not stored, and its whole record is treated as broken. Words of that record still in storage are removed by moving the write pointer back to the position where the record began. Later words of the record are accepted at the port and thrown away, up to and including its end marker. A sticky overflow flag tells the consumer to clean up any part of the record it has already taken.

A one-cycle pulse reports each record that was stored in full. The consumer drains words through a valid/ready interface. Each word comes out together with its end marker. `DEPTH` must be a power of two.

Top module: `rec_in_fifo`

## Requirements
- R1: For every cycle with `in_valid` high, `in_ack` is high in the following cycle. This holds whether the queue is full, empty or discarding.
- R2: A word that arrives while the queue is not full and not discarding is stored in arrival order. `level` gives the stored count, from 0 to `DEPTH`. Fullness is judged on the level before that cycle's pop.
- R3: A word that arrives while `level` equals `DEPTH` is not stored, and its record becomes broken.
- R4: Once a record is broken by a word that is not its last, its later words are not stored, up to and including the one with `in_last` high. The word after that begins a new record and is stored normally.
- R5: When a record breaks, its words still held in the queue are removed. `level` falls back to the count before that record began.
- R6: `ovf_flag` is set in the cycle after any overflow and stays set until a cycle with `ovf_clr` high. If an overflow and `ovf_clr` fall in the same cycle, the flag ends up set.
- R7: `out_valid` is high while `level` is non-zero. `out_data` and `out_last` show the oldest stored word. A cycle with `out_ready` and `out_valid` both high removes that word. With `out_ready` low, `level` and the data do not change.
- R8: `rec_done` pulses for one cycle after the edge that stores a word with `in_last` high. It never pulses for a broken record.
- R9: Words of a broken record that were already popped are not recalled. Only the words still stored are removed, so `level` can fall to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present |
| in_data | input | DW | Input word |
| in_last | input | 1 | Input word ends its record |
| in_ack | output | 1 | Acknowledge, one cycle after each input word |
| out_valid | output | 1 | A stored word is available |
| out_data | output | DW | Oldest stored word |
| out_last | output | 1 | Oldest stored word ends its record |
| out_ready | input | 1 | Consumer can take a word |
| rec_done | output | 1 | A complete record was stored |
| ovf_flag | output | 1 | Sticky overflow indication |
| ovf_clr | input | 1 | Clears the overflow flag |
| level | output | $clog2(DEPTH)+1 | Number of stored words |

## Verification
Two pairs of functions can fall in the same cycle here. The first pair is a pop and the write-pointer rollback. The bench stores two words of an open record, pops the first, and fills the queue until a further word overflows. The rollback must then land past the popped word and leave the level at zero, which is judged from `level` and `out_valid`. The second pair is a flag clear and a new overflow. The bench drives `ovf_clr` on the very word that overflows a full queue and expects the flag to be set afterwards. A sweep over record lengths from one to beyond the depth computes the expected level, flag and completion pulse for each length.

// File: rtl/rif_pkg.sv
package rif_pkg;
  typedef enum logic {
    WS_PASS = 1'b0,
    WS_DROP = 1'b1
  } wstate_e;
endpackage

// File: rtl/rif_ram.sv
module rif_ram #(
  parameter int W     = 9,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rif_flag.sv
module rif_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  p_flag_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> (flag_o == $past(flag_o)));
endmodule

// File: rtl/rif_ptrs.sv
module rif_ptrs
  import rif_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic          pop_req,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] level,
  output logic          not_empty,
  output logic          ovf_evt,
  output logic          commit
);
  logic [PW-1:0] wr_q, rd_q, rs_q;
  logic [PW-1:0] wr_d, rd_d, rs_d, rs_adj;
  wstate_e       st_q, st_d;
  logic          full, pop, take, store;

  assign level     = wr_q - rd_q;
  assign full      = (level == PW'(DEPTH));
  assign not_empty = (level != '0);
  assign pop       = pop_req && not_empty;
  assign take      = in_valid && (st_q == WS_PASS);
  assign store     = take && !full;
  assign ovf_evt   = take && full;
  assign commit    = store && in_last;
  assign we        = store;
  assign waddr     = wr_q[AW-1:0];
  assign raddr     = rd_q[AW-1:0];

  // start of the open record moves on when its first word is popped
  assign rs_adj = (pop && (rd_q == rs_q)) ? rs_q + PW'(1) : rs_q;

  always_comb begin
    wr_d = wr_q;
    rs_d = rs_adj;
    st_d = st_q;
    rd_d = pop ? rd_q + PW'(1) : rd_q;
    if (store) begin
      wr_d = wr_q + PW'(1);
      if (in_last) rs_d = wr_q + PW'(1);
    end
    if (ovf_evt) begin
      wr_d = rs_adj;
      rs_d = rs_adj;
      if (!in_last) st_d = WS_DROP;
    end
    if ((st_q == WS_DROP) && in_valid && in_last) st_d = WS_PASS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= '0;
      rd_q <= '0;
      rs_q <= '0;
      st_q <= WS_PASS;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
      rs_q <= rs_d;
      st_q <= st_d;
    end
  end

  p_level_max_r2: assert property (@(posedge clk) disable iff (rst)
    level <= PW'(DEPTH));
  p_full_no_store_r3: assert property (@(posedge clk) disable iff (rst)
    full |-> !we);
  p_drop_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ((st_q == WS_DROP) && in_valid) |=> (wr_q == $past(wr_q)));
  p_rollback_r5: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> (wr_q == rs_q));
  p_pop_step_r7: assert property (@(posedge clk) disable iff (rst)
    pop |=> ((rd_q - $past(rd_q)) == PW'(1)));
endmodule

// File: rtl/rec_in_fifo.sv
module rec_in_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          in_ack,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  input  logic          out_ready,
  output logic          rec_done,
  output logic          ovf_flag,
  input  logic          ovf_clr,
  output logic [PW-1:0] level
);
  logic          we, ovf_evt, commit;
  logic [AW-1:0] waddr, raddr;
  logic [DW:0]   rdata;

  rif_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
    .pop_req(out_ready), .we(we), .waddr(waddr), .raddr(raddr),
    .level(level), .not_empty(out_valid), .ovf_evt(ovf_evt), .commit(commit)
  );

  rif_ram #(.W(DW + 1), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata({in_last, in_data}),
    .raddr(raddr), .rdata(rdata)
  );

  rif_flag u_flag (
    .clk(clk), .rst(rst), .set_i(ovf_evt), .clr_i(ovf_clr), .flag_o(ovf_flag)
  );

  assign out_data = rdata[DW-1:0];
  assign out_last = rdata[DW];

  always_ff @(posedge clk) begin
    if (rst) begin
      in_ack   <= 1'b0;
      rec_done <= 1'b0;
    end else begin
      in_ack   <= in_valid;
      rec_done <= commit;
    end
  end

  p_ack_every_word_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> in_ack);
  p_done_after_last_r8: assert property (@(posedge clk) disable iff (rst)
    rec_done |-> $past(in_valid && in_last));
endmodule

// File: tb/sim_rec_in_fifo.sv
module sim_rec_in_fifo;
  localparam int DW = 8;
  localparam int DEPTH = 4;
  localparam int PW = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0, ovf_clr = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ack, out_valid, out_last, rec_done, ovf_flag;
  logic [DW-1:0] out_data;
  logic [PW-1:0] level;
  int errs = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rec_in_fifo #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ack(in_ack), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
    .rec_done(rec_done), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr), .level(level)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int d, input bit last, input bit exp_done, input bit clr);
    @(negedge clk);
    in_valid = 1'b1; in_data = DW'(d); in_last = last; ovf_clr = clr;
    @(posedge clk); #1;
    chk(in_ack == 1'b1, "R1 ack", int'(in_ack), 1);
    chk(rec_done == exp_done, "R8 rec_done", int'(rec_done), int'(exp_done));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; ovf_clr = 1'b0;
  endtask

  task automatic pop_chk(input int d, input bit last);
    @(negedge clk);
    out_ready = 1'b1; #1;
    chk(out_valid == 1'b1, "R7 out_valid", int'(out_valid), 1);
    chk(int'(out_data) == d, "R7 out_data", int'(out_data), d);
    chk(out_last == last, "R7 out_last", int'(out_last), int'(last));
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic lvl(input int n, input string req);
    chk(int'(level) == n, req, int'(level), n);
    chk(out_valid == (n != 0), {req, " out_valid"}, int'(out_valid), int'(n != 0));
  endtask

  task automatic clear_flag();
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    chk(ovf_flag == 1'b0, "R6 cleared", int'(ovf_flag), 0);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ack == 0 && rec_done == 0 && ovf_flag == 0, "R2 reset outputs", 0, 0);
    lvl(0, "R2 reset level");

    // sweep over record lengths from an empty queue (R2, R3, R4, R5, R8)
    for (int len = 1; len <= 6; len++) begin
      for (int i = 0; i < len; i++)
        send(len * 16 + i, i == len - 1, (i == len - 1) && (len <= DEPTH), 1'b0);
      idle();
      lvl(len <= DEPTH ? len : 0, "R5 sweep level");
      chk(ovf_flag == (len > DEPTH), "R3 sweep flag", int'(ovf_flag), int'(len > DEPTH));
      for (int i = 0; i < len && len <= DEPTH; i++)
        pop_chk(len * 16 + i, i == len - 1);
      if (len > DEPTH) begin
        clear_flag();
        send(8'hEE, 1'b1, 1'b1, 1'b0);   // R4 next record is stored
        idle();
        lvl(1, "R4 new record after drop");
        pop_chk(8'hEE, 1'b1);
      end
      lvl(0, "R7 drained");
    end

    // partial record rolled back behind a complete one (R3, R4, R5)
    send(8'hA0, 0, 0, 0); send(8'hA1, 1, 1, 0);
    send(8'hB0, 0, 0, 0); send(8'hB1, 0, 0, 0);
    idle(); lvl(4, "R2 full");
    send(8'hB2, 0, 0, 0);                 // arrives at full
    idle(); lvl(2, "R5 rolled back");
    chk(ovf_flag == 1, "R6 flag set", int'(ovf_flag), 1);
    send(8'hB3, 0, 0, 0); send(8'hB4, 1, 0, 0);
    idle(); lvl(2, "R4 broken words discarded");
    send(8'hC0, 1, 1, 0);
    idle(); lvl(3, "R4 new record");
    pop_chk(8'hA0, 0); pop_chk(8'hA1, 1); pop_chk(8'hC0, 1);
    lvl(0, "R7 empty");
    clear_flag();

    // pop of the open record's first word, then overflow (R9)
    send(8'hD0, 0, 0, 0); send(8'hD1, 0, 0, 0);
    idle();
    pop_chk(8'hD0, 0);
    lvl(1, "R9 after pop");
    send(8'hD2, 0, 0, 0); send(8'hD3, 0, 0, 0); send(8'hD4, 0, 0, 0);
    idle(); lvl(4, "R2 full again");
    send(8'hD5, 0, 0, 0);
    idle(); lvl(0, "R9 rollback past popped word");
    send(8'hD6, 1, 0, 0);
    idle(); lvl(0, "R4 last of broken dropped");
    chk(ovf_flag == 1, "R9 flag reports", int'(ovf_flag), 1);
    clear_flag();

    // hold with ready low, then clear and overflow together (R6, R7)
    send(8'hE0, 0, 0, 0); send(8'hE1, 0, 0, 0);
    send(8'hE2, 0, 0, 0); send(8'hE3, 1, 1, 0);
    idle();
    repeat (3) @(negedge clk);
    lvl(4, "R7 ready low holds");
    chk(int'(out_data) == 8'hE0, "R7 head stable", int'(out_data), 8'hE0);
    send(8'hF0, 1, 0, 1);                 // overflow with clear
    idle();
    chk(ovf_flag == 1, "R6 set wins", int'(ovf_flag), 1);
    lvl(4, "R3 stored data kept");
    @(negedge clk);
    chk(ovf_flag == 1, "R6 sticky", int'(ovf_flag), 1);
    clear_flag();
    pop_chk(8'hE0, 0); pop_chk(8'hE1, 0); pop_chk(8'hE2, 0); pop_chk(8'hE3, 1);
    lvl(0, "R7 final empty");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule